// File: doc/BRIEF.md
# Conversion Start and Busy Timer

This block produces the control timing for a successive-approximation converter. A conversion can be requested in two ways: a rising edge on an active-low start pin, or a control-register write that sets a software start bit. The request moves the track/hold into hold on the same clock edge and raises BUSY. The block then waits for a falling edge of the master clock, and from that edge it counts the conversion length in half master-clock periods. When the count ends, BUSY drops, the result register captures the externally supplied conversion data, and the software start bit clears so that software can set it again.

The block runs on a sample clock at twice the master-clock rate and generates the master clock itself, so every half period is a single tick. A request that reaches the block one tick before a master falling edge meets the setup window. A request that lands on the falling edge itself misses the window and waits for the next falling edge. The first request after reset runs a self-calibration pass of its own length instead of a conversion. Requests are ignored while BUSY is high and during a short acquisition guard after BUSY falls.

Top module: `conv_start_timer`

## Requirements
- R1: While idle, a rising edge on `start_n` (high at a sampling edge after it was low at the previous one) raises `busy` and `hold` at that edge.
- R2: While idle, a cycle with `ctrl_wr` and `ctrl_start` both 1 raises `busy`, `hold` and `sw_start` at that edge.
- R3: `mclk` is 0 in reset and toggles on every clock edge after reset. A master falling edge is a clock edge at which `mclk` goes from 1 to 0.
- R4: A request sampled while `mclk` is 0 meets setup. The conversion begins at the next edge and `busy` stays high for CONV_TICKS+1 cycles (34 with defaults).
- R5: A request sampled while `mclk` is 1 misses setup. The conversion begins one master falling edge later and `busy` stays high for CONV_TICKS+2 cycles (35 with defaults).
- R6: At the edge where `busy` falls after a conversion, `result` loads `conv_data`. It holds that value until the next conversion ends.
- R7: `sw_start` clears at the edge where `busy` falls.
- R8: The first request after reset runs calibration. `cal_active` is high with `busy`, and `busy` lasts CAL_TICKS+1 or CAL_TICKS+2 cycles under the same setup rule. `result` is not loaded.
- R9: Pin edges and software writes that arrive while `busy` is high are ignored: `sw_start` does not set and the conversion length is unchanged.
- R10: Requests sampled in the ACQ_TICKS-1 cycles after `busy` falls are ignored. A request sampled ACQ_TICKS cycles after the fall is accepted.
- R11: During reset `busy`, `hold`, `cal_active`, `sw_start`, `mclk` and `result` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, twice the master-clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_n | input | 1 | Active-low start pin; conversion requested on its rising edge |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_start | input | 1 | Software start bit carried by the control write |
| conv_data | input | DATA_W | Converter output, captured at end of conversion |
| mclk | output | 1 | Generated master clock |
| hold | output | 1 | Track/hold control, 1 = hold |
| busy | output | 1 | Conversion or calibration in progress |
| cal_active | output | 1 | Current busy period is the self-calibration pass |
| sw_start | output | 1 | Software start bit state |
| result | output | DATA_W | Latched conversion result |

## Verification
The case that is hardest to reach is a request that lands exactly on a master falling edge, since that edge depends on a free-running phase the ports only show through `mclk`. The stimulus watches `mclk` at each falling clock edge and releases the request only when the phase it needs is showing. This places both the setup-met and setup-missed cases on demand. The acquisition guard is probed the same way, counting cycles from the sampled fall of `busy` so that one write lands on the last ignored edge and the next on the first accepted one.

// File: rtl/conv_timer_pkg.sv
package conv_timer_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ALIGN = 2'd1,
      ST_RUN   = 2'd2,
      ST_ACQ   = 2'd3
   } seq_state_t;

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/ct_mclk_phase.sv
module ct_mclk_phase (
   input  logic clk,
   input  logic rst_n,
   output logic mclk,
   output logic fall_tick
);
   logic ph_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ph_q <= 1'b0;
      else        ph_q <= ~ph_q;
   end

   assign mclk      = ph_q;
   // the edge that takes the master clock from 1 to 0
   assign fall_tick = ph_q;
endmodule

// File: rtl/ct_start_detect.sv
module ct_start_detect (
   input  logic clk,
   input  logic rst_n,
   input  logic start_n,
   input  logic ctrl_wr,
   input  logic ctrl_start,
   input  logic idle,
   output logic start_evt,
   output logic sw_evt
);
   logic pin_q;
   logic pin_rise;
   logic sw_req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pin_q <= 1'b1;
      else        pin_q <= start_n;
   end

   assign pin_rise  = start_n & ~pin_q;
   assign sw_req    = ctrl_wr & ctrl_start;
   assign start_evt = idle & (pin_rise | sw_req);
   assign sw_evt    = idle & sw_req;
endmodule

// File: rtl/ct_seq.sv
module ct_seq #(
   parameter int CONV_TICKS = 33,
   parameter int CAL_TICKS  = 64,
   parameter int ACQ_TICKS  = 3,
   parameter bit CAL_ON     = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_evt,
   input  logic fall_tick,
   output logic idle,
   output logic busy,
   output logic cal_mode,
   output logic end_now
);
   import conv_timer_pkg::*;

   localparam int MAX_T = max3(CONV_TICKS, CAL_TICKS, ACQ_TICKS);
   localparam int CNT_W = $clog2(MAX_T + 1);
   localparam logic [CNT_W-1:0] CONV_LOAD = CNT_W'(CONV_TICKS - 1);
   localparam logic [CNT_W-1:0] CAL_LOAD  = CNT_W'(CAL_TICKS - 1);
   localparam logic [CNT_W-1:0] ACQ_LOAD  = CNT_W'(ACQ_TICKS - 2);

   seq_state_t       st_q;
   logic [CNT_W-1:0] cnt_q;
   logic             busy_q;
   logic             cal_q;
   logic             cal_pending;

   generate
      if (CAL_ON) begin : g_cal
         logic pend_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          pend_q <= 1'b1;
            else if (start_evt && st_q == ST_IDLE) pend_q <= 1'b0;
         end
         assign cal_pending = pend_q;
      end else begin : g_nocal
         assign cal_pending = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         cnt_q  <= '0;
         busy_q <= 1'b0;
         cal_q  <= 1'b0;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               if (start_evt) begin
                  st_q   <= ST_ALIGN;
                  busy_q <= 1'b1;
                  cal_q  <= cal_pending;
               end
            end
            ST_ALIGN: begin
               if (fall_tick) begin
                  st_q  <= ST_RUN;
                  cnt_q <= cal_q ? CAL_LOAD : CONV_LOAD;
               end
            end
            ST_RUN: begin
               if (cnt_q == '0) begin
                  st_q   <= ST_ACQ;
                  busy_q <= 1'b0;
                  cal_q  <= 1'b0;
                  cnt_q  <= ACQ_LOAD;
               end else begin
                  cnt_q <= cnt_q - CNT_W'(1);
               end
            end
            ST_ACQ: begin
               if (cnt_q == '0) st_q  <= ST_IDLE;
               else             cnt_q <= cnt_q - CNT_W'(1);
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign idle     = (st_q == ST_IDLE);
   assign busy     = busy_q;
   assign cal_mode = cal_q;
   assign end_now  = (st_q == ST_RUN) && (cnt_q == '0);
endmodule

// File: rtl/conv_start_timer.sv
module conv_start_timer #(
   parameter int DATA_W     = 12,
   parameter int CONV_TICKS = 33,
   parameter int CAL_TICKS  = 64,
   parameter int ACQ_TICKS  = 3,
   parameter bit CAL_ON     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_n,
   input  logic              ctrl_wr,
   input  logic              ctrl_start,
   input  logic [DATA_W-1:0] conv_data,
   output logic              mclk,
   output logic              hold,
   output logic              busy,
   output logic              cal_active,
   output logic              sw_start,
   output logic [DATA_W-1:0] result
);
   generate
      if (DATA_W < 1)      begin : g_bad_w   $error("DATA_W must be at least 1");     end
      if (CONV_TICKS < 2)  begin : g_bad_cv  $error("CONV_TICKS must be at least 2"); end
      if (CAL_TICKS < 2)   begin : g_bad_cl  $error("CAL_TICKS must be at least 2");  end
      if (ACQ_TICKS < 2)   begin : g_bad_aq  $error("ACQ_TICKS must be at least 2");  end
   endgenerate

   logic fall_tick;
   logic idle;
   logic start_evt;
   logic sw_evt;
   logic end_now;
   logic cal_mode;
   logic busy_w;
   logic sw_q;
   logic [DATA_W-1:0] res_q;

   ct_mclk_phase u_phase (
      .clk       (clk),
      .rst_n     (rst_n),
      .mclk      (mclk),
      .fall_tick (fall_tick)
   );

   ct_start_detect u_detect (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_n    (start_n),
      .ctrl_wr    (ctrl_wr),
      .ctrl_start (ctrl_start),
      .idle       (idle),
      .start_evt  (start_evt),
      .sw_evt     (sw_evt)
   );

   ct_seq #(
      .CONV_TICKS (CONV_TICKS),
      .CAL_TICKS  (CAL_TICKS),
      .ACQ_TICKS  (ACQ_TICKS),
      .CAL_ON     (CAL_ON)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_evt (start_evt),
      .fall_tick (fall_tick),
      .idle      (idle),
      .busy      (busy_w),
      .cal_mode  (cal_mode),
      .end_now   (end_now)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       sw_q <= 1'b0;
      else if (end_now) sw_q <= 1'b0;
      else if (sw_evt)  sw_q <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   res_q <= '0;
      else if (end_now && !cal_mode) res_q <= conv_data;
   end

   assign busy       = busy_w;
   assign hold       = busy_w;
   assign cal_active = cal_mode;
   assign sw_start   = sw_q;
   assign result     = res_q;
endmodule

// File: rtl/conv_start_timer_chk.sv
module conv_start_timer_chk #(
   parameter int DATA_W     = 12,
   parameter int CONV_TICKS = 33,
   parameter int CAL_TICKS  = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mclk,
   input logic              hold,
   input logic              busy,
   input logic              cal_active,
   input logic              sw_start,
   input logic [DATA_W-1:0] result
);
   localparam int LIM   = ((CAL_TICKS > CONV_TICKS) ? CAL_TICKS : CONV_TICKS) + 2;
   localparam int LEN_W = $clog2(LIM + 2);

   logic [LEN_W-1:0] run_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    run_len <= '0;
      else if (busy) run_len <= run_len + LEN_W'(1);
      else           run_len <= '0;
   end

   assert_mclk_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (mclk != $past(mclk)));

   assert_sw_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sw_start) |-> busy);

   assert_busy_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (run_len < LEN_W'(LIM)));

   assert_result_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !$fell(busy) |-> $stable(result));

   assert_sw_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> !sw_start);

   assert_cal_in_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cal_active |-> (busy && hold));

   assert_acq_guard_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |=> !busy);
endmodule

bind conv_start_timer conv_start_timer_chk #(
   .DATA_W     (DATA_W),
   .CONV_TICKS (CONV_TICKS),
   .CAL_TICKS  (CAL_TICKS)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mclk       (mclk),
   .hold       (hold),
   .busy       (busy),
   .cal_active (cal_active),
   .sw_start   (sw_start),
   .result     (result)
);

// File: tb/sim_conv_start_timer.sv
`timescale 1ns/1ps
module sim_conv_start_timer;
   localparam int DW = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_n = 1'b1;
   logic          ctrl_wr = 1'b0;
   logic          ctrl_start = 1'b0;
   logic [DW-1:0] conv_data = '0;
   logic          mclk, hold, busy, cal_active, sw_start;
   logic [DW-1:0] result;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   conv_start_timer #(.DATA_W(DW)) u0 (
      .clk(clk), .rst_n(rst_n), .start_n(start_n), .ctrl_wr(ctrl_wr),
      .ctrl_start(ctrl_start), .conv_data(conv_data), .mclk(mclk), .hold(hold),
      .busy(busy), .cal_active(cal_active), .sw_start(sw_start), .result(result)
   );

   // {software request, mclk phase at request, data, expected busy cycles}
   localparam logic [21:0] VEC [0:5] = '{
      {1'b0, 1'b0, 12'hA5C, 8'd34},
      {1'b0, 1'b1, 12'h3F0, 8'd35},
      {1'b1, 1'b0, 12'hFFF, 8'd34},
      {1'b1, 1'b1, 12'h000, 8'd35},
      {1'b0, 1'b1, 12'h801, 8'd35},
      {1'b1, 1'b0, 12'h7FE, 8'd34}
   };

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   // release a request on the mclk phase asked for, then count busy cycles;
   // poke >= 0 injects a software write and a pin edge during busy
   task automatic run(input bit use_sw, input bit ph, input int poke,
                      output int len, output bit cal_seen, output bit sw_seen);
      len = 0; cal_seen = 0; sw_seen = 0;
      if (!use_sw) begin
         @(negedge clk); start_n = 1'b0;
      end
      @(negedge clk);
      while (mclk != ph) @(negedge clk);
      if (use_sw) begin ctrl_wr = 1'b1; ctrl_start = 1'b1; end
      else        start_n = 1'b1;
      @(negedge clk);
      ctrl_wr = 1'b0; ctrl_start = 1'b0;
      cal_seen = cal_active;
      while (busy && len < 1000) begin
         if (sw_start) sw_seen = 1;
         if (poke >= 0) begin
            if (len == poke) begin ctrl_wr = 1'b1; ctrl_start = 1'b1; end
            else begin ctrl_wr = 1'b0; ctrl_start = 1'b0; end
            if (len == poke + 3) start_n = 1'b0;
            if (len == poke + 5) start_n = 1'b1;
         end
         len++;
         @(negedge clk);
      end
      ctrl_wr = 1'b0; ctrl_start = 1'b0; start_n = 1'b1;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         summary();
         $finish;
      end
   end

   initial begin
      int len;
      bit cs, ss, p;
      // R11 reset state
      repeat (3) @(negedge clk);
      chk(busy == 0 && hold == 0, "R11", "busy/hold in reset", busy, 0);
      chk(cal_active == 0 && sw_start == 0, "R11", "cal/sw in reset", cal_active, 0);
      chk(mclk == 0, "R11", "mclk in reset", mclk, 0);
      chk(result == 0, "R11", "result in reset", result, 0);
      rst_n = 1'b1;
      // R3 master clock toggles
      @(negedge clk); p = mclk;
      @(negedge clk);
      chk(mclk != p && p == 1, "R3", "mclk toggle", mclk, !p);

      // R8 first request calibrates (setup met -> CAL_TICKS+1)
      conv_data = 12'h5A5;
      run(1'b0, 1'b0, -1, len, cs, ss);
      chk(cs == 1, "R8", "cal_active during first run", cs, 1);
      chk(len == 65, "R8", "calibration length", len, 65);
      chk(result == 0, "R8", "result after calibration", result, 0);

      // table walk: R1/R2 start sources, R4/R5 setup, R6 capture, R7 clear
      for (int i = 0; i < 6; i++) begin
         logic [21:0] v;
         v = VEC[i];
         repeat (4) @(negedge clk);
         conv_data = v[19:8];
         run(v[21], v[20], -1, len, cs, ss);
         chk(len == int'(v[7:0]), v[20] ? "R5" : "R4", "busy length", len, v[7:0]);
         chk(cs == 0, "R8", "no calibration after first", cs, 0);
         chk(result == v[19:8], "R6", "captured result", result, v[19:8]);
         chk(sw_start == 0, "R7", "sw bit cleared at end", sw_start, 0);
         if (v[21]) chk(ss == 1, "R2", "sw bit set while busy", ss, 1);
         else       chk(ss == 0, "R1", "pin start leaves sw bit clear", ss, 0);
      end

      // R9 requests during busy ignored
      repeat (4) @(negedge clk);
      conv_data = 12'h155;
      run(1'b0, 1'b0, 6, len, cs, ss);
      chk(ss == 0, "R9", "sw write during busy", ss, 0);
      chk(len == 34, "R9", "length with requests during busy", len, 34);
      repeat (6) @(negedge clk);
      chk(busy == 0, "R9", "no restart after busy", busy, 0);
      chk(result == 12'h155, "R6", "result held", result, 12'h155);

      // R10 acquisition guard
      repeat (4) @(negedge clk);
      conv_data = 12'h2C3;
      run(1'b1, 1'b1, -1, len, cs, ss);
      @(negedge clk);
      ctrl_wr = 1'b1; ctrl_start = 1'b1;
      @(negedge clk);
      ctrl_wr = 1'b0; ctrl_start = 1'b0;
      chk(busy == 0 && sw_start == 0, "R10", "request inside guard", busy, 0);
      p = mclk;
      conv_data = 12'h9E1;
      ctrl_wr = 1'b1; ctrl_start = 1'b1;
      @(negedge clk);
      ctrl_wr = 1'b0; ctrl_start = 1'b0;
      chk(busy == 1 && hold == 1, "R10", "request after guard", busy, 1);
      len = 0;
      while (busy && len < 1000) begin len++; @(negedge clk); end
      chk(len == (p ? 35 : 34), "R10", "length after guard", len, p ? 35 : 34);
      chk(result == 12'h9E1, "R6", "result after guarded run", result, 12'h9E1);

      // second reset: R11 then R8 calibration with missed setup
      repeat (3) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk(result == 0 && busy == 0, "R11", "result cleared by reset", result, 0);
      rst_n = 1'b1;
      run(1'b0, 1'b1, -1, len, cs, ss);
      chk(cs == 1 && len == 66, "R8", "calibration missed setup", len, 66);
      repeat (4) @(negedge clk);
      conv_data = 12'h6B7;
      run(1'b1, 1'b0, -1, len, cs, ss);
      chk(len == 34 && result == 12'h6B7, "R4", "normal run after calibration", len, 34);

      finished = 1;
      summary();
      $finish;
   end
endmodule